// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash and turns one request into the full series of bus cycles that the flash needs. A request names one of four operations: byte program, whole-array erase, page erase or identifier readout. The sequencer issues the unlock address/data pairs, writes the command, then waits for the embedded algorithm to finish. It waits either by checking bit 7 of a status read against the value it expects, or by reading until bit 6 stops alternating. Once the operation finishes, it reads the array once more and reports the result.

Requests arrive on a valid/ready channel. `req_ready` is high only while the sequencer is idle, so a request waits upstream for as long as an operation runs, and holding `req_valid` high during that time has no effect. The completion side is a plain one-cycle `done` pulse with `err` and `result`. Each bus cycle is a single-clock write or read strobe. The flash side stretches a cycle by holding `bus_wait` high, and the strobe then stays up with address and data unchanged until `bus_wait` drops.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0 and neither `bus_we` nor `bus_re` is high, and no strobe is raised while idle.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays 0 from the next cycle until after the `done` pulse, and requests offered in that window change neither the bus traffic nor the result.
- R3: Program (`req_op`=0) writes AA to 5555, 55 to 2AAA, A0 to 5555, and then the request data to the request address.
- R4: Before a program, the target address is read once. If the new data has a 1 in any bit that is 0 in that read, the request ends with `err`=1 and no write cycle.
- R5: Whole-array erase (`req_op`=1) writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555.
- R6: Page erase (`req_op`=2) writes the same first five cycles as R5, then 50 to the request address.
- R7: With `req_toggle`=0, the sequencer reads the request address until bit 7 of a read equals the expected value: data bit 7 for a program, 1 for an erase.
- R8: With `req_toggle`=1, the operation is finished at the first poll read whose bit 6 equals bit 6 of the poll read just before it.
- R9: After polling completes, one more read of the request address is made, and `result[7:0]` carries that byte. For a program, `err` is 1 if that byte differs from the request data.
- R10: If the completing poll read would be read number k, the request finishes with `err`=1 when k exceeds `poll_limit`, after exactly `poll_limit` poll reads.
- R11: Identifier readout (`req_op`=3) writes AA@5555, 55@2AAA, 90@5555, reads 0000 then 0001, and writes F0 to 5555. `result` = {byte read at 0001, byte read at 0000}.
- R12: Only one of `bus_we` and `bus_re` is high at a time. While `bus_wait` is high the strobe, `bus_addr` and `bus_wdata` hold, and each cycle takes effect exactly once, on the clock where `bus_wait` is low.
- R13: `done` is a single-cycle pulse, and `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_op | input | 2 | 0 program, 1 whole erase, 2 page erase, 3 identifier |
| req_addr | input | ADDR_W | Target address, or any address inside the page |
| req_data | input | DATA_W | Byte to program |
| req_toggle | input | 1 | 1 selects bit-6 toggle polling, 0 bit-7 polling |
| poll_limit | input | LIMIT_W | Maximum number of poll reads |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure, valid with done |
| result | output | 2*DATA_W | Final read byte, or identifier pair |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | DATA_W | Flash write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_wait | input | 1 | Flash stretches the current cycle |
| bus_rdata | input | DATA_W | Read data, valid on the clock where bus_re is high and bus_wait low |

## Verification
The hardest case to reach from the ports is the exact boundary between finishing in time and timing out. In toggle polling, the read that completes depends on the phase of the last alternating bit 6 relative to the settled data bit. The bench therefore uses a scripted flash that returns a chosen number of busy reads and, in bit-7 mode, one settling read whose low bits are wrong. It sweeps busy count, poll limit, data byte and polling mode, and computes the completing read number arithmetically, so each limit lands on both sides of that boundary. Wait stretching is interleaved in half of the runs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_CHIP  = 2'd1,
    OP_PAGE  = 2'd2,
    OP_IDENT = 2'd3
  } flash_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_CMD, S_POLL, S_FIN, S_ID0, S_ID1, S_EXIT, S_DONE
  } seq_state_e;

  localparam logic [7:0] BYTE_UNLOCK1 = 8'hAA;
  localparam logic [7:0] BYTE_UNLOCK2 = 8'h55;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ESETUP  = 8'h80;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_PAGE    = 8'h50;
  localparam logic [7:0] BYTE_IDENT   = 8'h90;
  localparam logic [7:0] BYTE_LEAVE   = 8'hF0;
endpackage

// File: rtl/flash_seq_table.sv
module flash_seq_table
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
  input  flash_op_e         op,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [DATA_W-1:0] cyc_data,
  output logic              cyc_last
);
  always_comb begin
    cyc_addr = UNLOCK_A;
    cyc_data = DATA_W'(BYTE_UNLOCK1);
    cyc_last = 1'b0;
    case (idx)
      IDX_W'(1), IDX_W'(4): begin
        cyc_addr = UNLOCK_B;
        cyc_data = DATA_W'(BYTE_UNLOCK2);
      end
      IDX_W'(2): begin
        case (op)
          OP_PROG:  cyc_data = DATA_W'(BYTE_PROG);
          OP_IDENT: cyc_data = DATA_W'(BYTE_IDENT);
          default:  cyc_data = DATA_W'(BYTE_ESETUP);
        endcase
        cyc_last = (op == OP_IDENT);
      end
      IDX_W'(3): begin
        if (op == OP_PROG) begin
          cyc_addr = tgt_addr;
          cyc_data = tgt_data;
          cyc_last = 1'b1;
        end
      end
      IDX_W'(5): begin
        cyc_last = 1'b1;
        if (op == OP_PAGE) begin
          cyc_addr = tgt_addr;
          cyc_data = DATA_W'(BYTE_PAGE);
        end else begin
          cyc_data = DATA_W'(BYTE_CHIP);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_poll_unit.sv
module flash_poll_unit #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rd_ack,
  input  logic               bit7,
  input  logic               bit6,
  input  logic               exp7,
  input  logic               use_toggle,
  input  logic [LIMIT_W-1:0] limit,
  output logic               fin,
  output logic               tmo
);
  logic [LIMIT_W-1:0] cnt;
  logic               prev6;
  logic               have_prev;
  logic [LIMIT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + (LIMIT_W+1)'(1);

  always_comb begin
    if (use_toggle) fin = rd_ack && have_prev && (bit6 == prev6);
    else            fin = rd_ack && (bit7 == exp7);
    tmo = rd_ack && !fin && (cnt_next >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      prev6     <= 1'b0;
      have_prev <= 1'b0;
    end else if (clr) begin
      cnt       <= '0;
      have_prev <= 1'b0;
    end else if (rd_ack) begin
      cnt       <= cnt_next[LIMIT_W-1:0];
      prev6     <= bit6;
      have_prev <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int LIMIT_W = 16,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 16'h5555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 16'h2AAA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_data,
  input  logic                req_toggle,
  input  logic [LIMIT_W-1:0]  poll_limit,
  output logic                done,
  output logic                err,
  output logic [2*DATA_W-1:0] result,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_we,
  output logic                bus_re,
  input  logic                bus_wait,
  input  logic [DATA_W-1:0]   bus_rdata
);
  localparam int IDX_W = 3;
  localparam int RES_W = 2 * DATA_W;

  seq_state_e          state;
  flash_op_e           q_op;
  logic [ADDR_W-1:0]   q_addr;
  logic [DATA_W-1:0]   q_data;
  logic                q_tog;
  logic [LIMIT_W-1:0]  q_limit;
  logic [IDX_W-1:0]    idx;
  logic [RES_W-1:0]    res;
  logic                errf;

  logic [ADDR_W-1:0]   tbl_addr;
  logic [DATA_W-1:0]   tbl_data;
  logic                tbl_last;
  logic                ack;
  logic                rd_ack;
  logic                poll_clr;
  logic                poll_fin;
  logic                poll_tmo;
  logic                exp7;

  flash_seq_table #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B)
  ) u_table (
    .op(q_op), .idx(idx), .tgt_addr(q_addr), .tgt_data(q_data),
    .cyc_addr(tbl_addr), .cyc_data(tbl_data), .cyc_last(tbl_last)
  );

  assign exp7     = (q_op == OP_PROG) ? q_data[DATA_W-1] : 1'b1;
  assign rd_ack   = (state == S_POLL) && ack;
  assign poll_clr = (state == S_CMD) && ack && tbl_last;

  flash_poll_unit #(.LIMIT_W(LIMIT_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .rd_ack(rd_ack),
    .bit7(bus_rdata[DATA_W-1]), .bit6(bus_rdata[DATA_W-2]),
    .exp7(exp7), .use_toggle(q_tog), .limit(q_limit),
    .fin(poll_fin), .tmo(poll_tmo)
  );

  always_comb begin
    bus_we    = (state == S_CMD) || (state == S_EXIT);
    bus_re    = (state == S_PRE) || (state == S_POLL) || (state == S_FIN) ||
                (state == S_ID0) || (state == S_ID1);
    bus_addr  = q_addr;
    bus_wdata = '0;
    case (state)
      S_CMD:  begin bus_addr = tbl_addr; bus_wdata = tbl_data; end
      S_EXIT: begin bus_addr = UNLOCK_A; bus_wdata = DATA_W'(BYTE_LEAVE); end
      S_ID0:  bus_addr = ADDR_W'(0);
      S_ID1:  bus_addr = ADDR_W'(1);
      default: ;
    endcase
    ack = (bus_we || bus_re) && !bus_wait;
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = done && errf;
  assign result    = res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      q_op    <= OP_PROG;
      q_addr  <= '0;
      q_data  <= '0;
      q_tog   <= 1'b0;
      q_limit <= '0;
      idx     <= '0;
      res     <= '0;
      errf    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          q_op    <= flash_op_e'(req_op);
          q_addr  <= req_addr;
          q_data  <= req_data;
          q_tog   <= req_toggle;
          q_limit <= poll_limit;
          idx     <= '0;
          errf    <= 1'b0;
          state   <= (flash_op_e'(req_op) == OP_PROG) ? S_PRE : S_CMD;
        end
        S_PRE: if (ack) begin
          if (|(q_data & ~bus_rdata)) begin
            errf  <= 1'b1;
            res   <= RES_W'(bus_rdata);
            state <= S_DONE;
          end else begin
            state <= S_CMD;
          end
        end
        S_CMD: if (ack) begin
          if (tbl_last) state <= (q_op == OP_IDENT) ? S_ID0 : S_POLL;
          else          idx   <= idx + IDX_W'(1);
        end
        S_POLL: begin
          if (poll_fin) state <= S_FIN;
          else if (poll_tmo) begin
            errf  <= 1'b1;
            state <= S_DONE;
          end
        end
        S_FIN: if (ack) begin
          res <= RES_W'(bus_rdata);
          if (q_op == OP_PROG && bus_rdata != q_data) errf <= 1'b1;
          state <= S_DONE;
        end
        S_ID0: if (ack) begin
          res[DATA_W-1:0] <= bus_rdata;
          state <= S_ID1;
        end
        S_ID1: if (ack) begin
          res[RES_W-1:DATA_W] <= bus_rdata;
          state <= S_EXIT;
        end
        S_EXIT: if (ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              err,
  input logic              bus_we,
  input logic              bus_re,
  input logic              bus_wait,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(bus_we || bus_re));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_hold_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wait) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata)));

  assert_hold_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_wait) |=> (bus_re && $stable(bus_addr)));

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_data = 8'h0;
  logic        req_toggle = 1'b0;
  logic [15:0] poll_limit = 16'd1;
  logic        done, err;
  logic [15:0] result;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, bus_re;
  logic        bus_wait = 1'b0;
  logic [7:0]  bus_rdata;

  always #2 clk = ~clk;

  flash_prog_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_toggle(req_toggle), .poll_limit(poll_limit), .done(done), .err(err),
    .result(result), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_wait(bus_wait), .bus_rdata(bus_rdata)
  );

  int tests = 0;
  int fails = 0;

  // scripted flash
  int          m_wcount;
  int          m_arm;
  int          m_busy_n;
  int          busy;
  logic        settle;
  logic        tog;
  logic        m_tog_mode;
  logic        m_id;
  logic [7:0]  arr;
  logic [7:0]  m_after;
  logic [15:0] log_a [0:7];
  logic [7:0]  log_d [0:7];
  logic        wait_en = 1'b0;
  int          wcyc = 0;

  always @(posedge clk) begin
    if (bus_we && !bus_wait) begin
      if (m_wcount < 8) begin
        log_a[m_wcount] <= bus_addr;
        log_d[m_wcount] <= bus_wdata;
      end
      m_wcount <= m_wcount + 1;
      if (m_wcount + 1 == m_arm) begin
        busy   <= m_busy_n;
        arr    <= m_after;
        settle <= !m_tog_mode;
        tog    <= 1'b0;
      end
    end
    if (bus_re && !bus_wait) begin
      if (busy > 0) begin
        busy <= busy - 1;
        tog  <= ~tog;
      end else if (settle) begin
        settle <= 1'b0;
      end
    end
  end

  always_comb begin
    if (busy > 0)     bus_rdata = {~arr[7], tog, 6'h00};
    else if (settle)  bus_rdata = {arr[7], ~arr[6:0]};
    else if (m_id)    bus_rdata = (bus_addr == 16'h0000) ? 8'hC3 :
                                  (bus_addr == 16'h0001) ? 8'h5A : 8'h00;
    else              bus_rdata = arr;
  end

  always @(negedge clk) begin
    bus_wait <= wait_en && (wcyc % 3 == 1);
    wcyc <= wcyc + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_w(input int op, input int i,
                                        input logic [15:0] a, input logic [7:0] d);
    logic [7:0] third;
    third = (op == 0) ? 8'hA0 : (op == 3) ? 8'h90 : 8'h80;
    case (i)
      0: return {16'h5555, 8'hAA};
      1: return {16'h2AAA, 8'h55};
      2: return {16'h5555, third};
      3: return (op == 0) ? {a, d} : (op == 3) ? {16'h5555, 8'hF0} : {16'h5555, 8'hAA};
      4: return {16'h2AAA, 8'h55};
      default: return (op == 2) ? {a, 8'h50} : {16'h5555, 8'h10};
    endcase
  endfunction

  task automatic prep(input logic [7:0] old, input logic [7:0] after_v, input int arm,
                      input int n, input logic tm, input logic idm);
    @(negedge clk);
    m_wcount   <= 0;
    busy       <= 0;
    settle     <= 1'b0;
    tog        <= 1'b0;
    arr        <= old;
    m_after    <= after_v;
    m_arm      <= arm;
    m_busy_n   <= n;
    m_tog_mode <= tm;
    m_id       <= idm;
  endtask

  logic        g_err;
  logic [15:0] g_res;

  task automatic run(input int op, input logic [15:0] a, input logic [7:0] d,
                     input logic tm, input int lim, input logic spam);
    int cnt;
    @(negedge clk);
    req_op = 2'(op); req_addr = a; req_data = d; req_toggle = tm;
    poll_limit = 16'(lim); req_valid = 1'b1;
    @(negedge clk);
    if (spam) begin
      req_op = 2'd1; req_addr = 16'hBEEF; req_data = 8'h00;
    end else begin
      req_valid = 1'b0;
    end
    cnt = 0;
    while (!done && cnt < 3000) begin
      if (spam) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
      @(negedge clk);
      cnt++;
    end
    if (cnt >= 3000) chk(1'b0, "watchdog", cnt, 0);
    g_err = err;
    g_res = result;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!done, "R13 done single cycle", done, 0);
  endtask

  initial begin
    prep(8'hFF, 8'hFF, 99, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !bus_we && !bus_re, "R1 reset state",
        {req_ready, done, bus_we, bus_re}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_we && !bus_re, "R1 idle after reset", req_ready, 1);

    // program sweep: busy count x poll limit x polling mode
    for (int md = 0; md < 2; md++) begin
      for (int n = 0; n < 6; n++) begin
        for (int lim = 1; lim < 8; lim++) begin
          logic [7:0] d;
          int k;
          d = 8'((n * 53 + lim * 17 + md * 90) & 255);
          if (md == 0) k = n + 1;
          else k = (n >= 1 && d[6] == 1'((n - 1) & 1)) ? n + 1 : n + 2;
          wait_en = lim[0];
          prep(8'hFF, d, 4, n, md[0], 1'b0);
          run(0, 16'(16'h1200 + n * 16 + lim), d, md[0], lim, 1'b0);
          if (md == 0) chk(g_err == (k > lim), "R7 R10 data-poll err", g_err, k > lim);
          else         chk(g_err == (k > lim), "R8 R10 toggle err", g_err, k > lim);
          if (k <= lim) chk(g_res[7:0] == d, "R9 reread result", g_res[7:0], d);
          chk(m_wcount == 4, "R3 R12 write count", m_wcount, 4);
          for (int i = 0; i < 4; i++)
            chk({log_a[i], log_d[i]} ==
                exp_w(0, i, 16'(16'h1200 + n * 16 + lim), d),
                "R3 program cycle", {log_a[i], log_d[i]},
                exp_w(0, i, 16'(16'h1200 + n * 16 + lim), d));
        end
      end
    end
    wait_en = 1'b0;

    // R4 bit set on a cleared bit
    prep(8'h0F, 8'h1F, 4, 0, 1'b0, 1'b0);
    run(0, 16'h0040, 8'h1F, 1'b0, 5, 1'b0);
    chk(g_err == 1'b1, "R4 reject 0 to 1", g_err, 1);
    chk(m_wcount == 0, "R4 no write", m_wcount, 0);

    // R9 verify mismatch after completion
    prep(8'hFF, 8'h35, 4, 2, 1'b0, 1'b0);
    run(0, 16'h0041, 8'h34, 1'b0, 9, 1'b0);
    chk(g_err == 1'b1, "R9 verify mismatch", g_err, 1);
    chk(g_res[7:0] == 8'h35, "R9 mismatch byte", g_res[7:0], 8'h35);

    // R5 whole erase, data polling, with wait
    wait_en = 1'b1;
    prep(8'h00, 8'hFF, 6, 3, 1'b0, 1'b0);
    run(1, 16'h7777, 8'h00, 1'b0, 10, 1'b0);
    chk(!g_err && g_res[7:0] == 8'hFF, "R5 R7 erase result", g_res[7:0], 8'hFF);
    chk(m_wcount == 6, "R5 write count", m_wcount, 6);
    for (int i = 0; i < 6; i++)
      chk({log_a[i], log_d[i]} == exp_w(1, i, 16'h7777, 8'h00), "R5 erase cycle",
          {log_a[i], log_d[i]}, exp_w(1, i, 16'h7777, 8'h00));
    wait_en = 1'b0;

    // R6 page erase, toggle polling: busy 4, settled bit6=1 -> completes on read 5
    prep(8'h00, 8'hFF, 6, 4, 1'b1, 1'b0);
    run(2, 16'h3456, 8'h00, 1'b1, 5, 1'b0);
    chk(!g_err && g_res[7:0] == 8'hFF, "R6 R8 page erase result", g_res[7:0], 8'hFF);
    chk(m_wcount == 6, "R6 write count", m_wcount, 6);
    for (int i = 0; i < 6; i++)
      chk({log_a[i], log_d[i]} == exp_w(2, i, 16'h3456, 8'h00), "R6 page cycle",
          {log_a[i], log_d[i]}, exp_w(2, i, 16'h3456, 8'h00));

    // R10 erase timeout: needs 6 reads, limit 3
    prep(8'h00, 8'hFF, 6, 5, 1'b0, 1'b0);
    run(1, 16'h0000, 8'h00, 1'b0, 3, 1'b0);
    chk(g_err == 1'b1, "R10 erase timeout", g_err, 1);

    // R11 identifier readout with spam requests for R2
    prep(8'h00, 8'h00, 99, 0, 1'b0, 1'b1);
    run(3, 16'h9999, 8'h00, 1'b0, 1, 1'b1);
    chk(!g_err && g_res == 16'h5AC3, "R11 identifier pair", g_res, 16'h5AC3);
    chk(m_wcount == 4, "R2 R11 write count", m_wcount, 4);
    for (int i = 0; i < 4; i++)
      chk({log_a[i], log_d[i]} == exp_w(3, i, 16'h0, 8'h0), "R11 ident cycle",
          {log_a[i], log_d[i]}, exp_w(3, i, 16'h0, 8'h0));
    @(negedge clk);
    chk(req_ready && !bus_we && !bus_re, "R1 R2 idle after spam", req_ready, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule